// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This unit turns one memory-access request into an effective address. It accepts a base pointer, an index, a signed displacement, an addressing mode, a 2-bit scale code and an operand size. The index can be shifted left by the explicit scale code, or by an amount taken from the operand size. A fourth mode steps the base pointer up or down by one element. In that mode the unit also returns the updated pointer so that it can be written back to the register file.

Each accepted request produces a registered result one clock later. Arithmetic is 32 bits wide and wraps modulo 2^32. Instruction decode, register access and the memory port are handled by the surrounding pipeline.

Top module: `agu_scaled`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `wb_en` are 0, and `ea` and `wb_data` are 0. The reset is asynchronous.
- R2: A request is accepted when `in_valid` is 1 at a rising clock edge. Its result appears after that edge with `out_valid` high for exactly one cycle. Back-to-back requests give back-to-back results.
- R3: Mode code 00 gives `ea = base + sext(disp)`. The 16-bit displacement is sign-extended to 32 bits. In this mode the index, scale and operand size have no effect.
- R4: Mode code 01 gives `ea = base + (index << scale) + sext(disp)`. Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R5: Mode code 10 gives `ea = base + (index << opsize) + sext(disp)`. Opsize 00 is byte (x1), 01 is halfword (x2), 10 is word (x4) and 11 is doubleword (x8). The scale code has no effect in this mode.
- R6: In mode 01 the operand size has no effect. A scale larger than the element, such as byte size with scale code 3, is honoured.
- R7: For a byte operand, mode 10 yields the same address as mode 01 with scale code 0.
- R8: Mode code 11 with `dir`=0 is post-increment. `ea = base` and `wb_data = base + (1 << opsize)`.
- R9: Mode code 11 with `dir`=1 is pre-decrement. `ea = wb_data = base - (1 << opsize)`.
- R10: `wb_en` is high only on the result of a mode-11 request. For any other request `wb_data` is 0. In mode 11 the index, scale and displacement have no effect.
- R11: All sums and differences wrap modulo 2^32.
- R12: In a cycle with no request, `out_valid` and `wb_en` are 0, and `ea` and `wb_data` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Addressing mode code |
| scale | input | 2 | Explicit index shift amount |
| opsize | input | 2 | Operand size code |
| dir | input | 1 | Auto-modify direction: 0 post-increment, 1 pre-decrement |
| base | input | 32 | Base pointer |
| index | input | 32 | Index value |
| disp | input | 16 | Signed displacement |
| out_valid | output | 1 | Result strobe |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Pointer writeback enable |
| wb_data | output | 32 | Updated pointer |

## Verification
Each result is a pure function of the request one edge earlier. A wrong shift source, a missing sign extension or a wrong pointer step therefore shows up as a wrong `ea` or `wb_data` in the very next cycle. A stuck or leaked strobe appears as `out_valid` or `wb_en` disagreeing with the request of the previous cycle. Corrupted holding registers show as `ea` changing across an idle cycle.

// File: rtl/agu_scaled.sv
module agu_scaled #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [1:0]    mode,
  input  logic [1:0]    scale,
  input  logic [1:0]    opsize,
  input  logic          dir,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [DW-1:0] disp,
  output logic          out_valid,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_data
);
  localparam logic [1:0] M_DISP = 2'b00;
  localparam logic [1:0] M_XSCL = 2'b01;
  localparam logic [1:0] M_AMOD = 2'b11;

  logic [1:0]    shamt;
  logic          is_amod;
  logic [AW-1:0] disp_x, idx_term, step, sum_addr, mod_ptr, ea_nxt;

  assign shamt    = (mode == M_XSCL) ? scale : opsize;
  assign is_amod  = (mode == M_AMOD);
  assign disp_x   = {{(AW-DW){disp[DW-1]}}, disp};
  assign idx_term = (mode == M_DISP) ? '0 : (index << shamt);
  assign step     = {{(AW-1){1'b0}}, 1'b1} << opsize;
  assign sum_addr = base + idx_term + disp_x;
  assign mod_ptr  = dir ? (base - step) : (base + step);
  assign ea_nxt   = is_amod ? (dir ? mod_ptr : base) : sum_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      wb_en     <= 1'b0;
      ea        <= '0;
      wb_data   <= '0;
    end else begin
      out_valid <= in_valid;
      wb_en     <= in_valid & is_amod;
      if (in_valid) begin
        ea      <= ea_nxt;
        wb_data <= is_amod ? mod_ptr : '0;
      end
    end
  end
endmodule

// File: rtl/agu_scaled_chk.sv
module agu_scaled_chk #(
  parameter int AW = 32,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [1:0]    mode,
  input logic          dir,
  input logic [AW-1:0] base,
  input logic [DW-1:0] disp,
  input logic          out_valid,
  input logic [AW-1:0] ea,
  input logic          wb_en,
  input logic [AW-1:0] wb_data
);
  // R2
  lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && !wb_en));
  // R12
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(ea) && $stable(wb_data)));
  // R10
  wben_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> out_valid);
  // R10
  amod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11) |=> wb_en);
  // R3
  disp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b00) |=>
      (ea == $past(base) + {{(AW-DW){$past(disp[DW-1])}}, $past(disp)}));
  // R8
  postinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11 && !dir) |=> (ea == $past(base)));
  // R9
  predec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && mode == 2'b11 && dir) |=> (ea == wb_data));
endmodule

bind agu_scaled agu_scaled_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .dir(dir),
  .base(base), .disp(disp), .out_valid(out_valid), .ea(ea),
  .wb_en(wb_en), .wb_data(wb_data)
);

// File: tb/agu_scaled_bench.sv
module agu_scaled_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [1:0]  mode = '0, scale = '0, opsize = '0;
  logic        dir = 1'b0;
  logic [31:0] base = '0, index = '0;
  logic [15:0] disp = '0;
  logic        out_valid, wb_en;
  logic [31:0] ea, wb_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  agu_scaled u_agu_scaled (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .scale(scale),
    .opsize(opsize), .dir(dir), .base(base), .index(index), .disp(disp),
    .out_valid(out_valid), .ea(ea), .wb_en(wb_en), .wb_data(wb_data)
  );

  typedef struct packed {
    logic [1:0]  m;
    logic [1:0]  sc;
    logic [1:0]  sz;
    logic        d;
    logic [31:0] b;
    logic [31:0] x;
    logic [15:0] dp;
    logic [31:0] e;
    logic [31:0] w;
    logic        we;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{2'd0, 2'd3, 2'd2, 1'b0, 32'h0000_1000, 32'h0000_0009, 16'h0010, 32'h0000_1010, 32'h0, 1'b0, 4'd3}, // R3
    '{2'd0, 2'd0, 2'd0, 1'b0, 32'h0000_1000, 32'h0000_0000, 16'hFFF0, 32'h0000_0FF0, 32'h0, 1'b0, 4'd3}, // R3 negative
    '{2'd1, 2'd2, 2'd0, 1'b0, 32'h0000_2000, 32'h0000_0003, 16'h0004, 32'h0000_2010, 32'h0, 1'b0, 4'd4}, // R4
    '{2'd1, 2'd3, 2'd0, 1'b0, 32'h0000_0100, 32'h0000_0005, 16'h0000, 32'h0000_0128, 32'h0, 1'b0, 4'd6}, // R6
    '{2'd1, 2'd0, 2'd3, 1'b0, 32'h0000_0100, 32'h0000_0005, 16'h0001, 32'h0000_0106, 32'h0, 1'b0, 4'd4}, // R4 x1
    '{2'd2, 2'd3, 2'd0, 1'b0, 32'h0000_0100, 32'h0000_0005, 16'h0001, 32'h0000_0106, 32'h0, 1'b0, 4'd7}, // R7
    '{2'd2, 2'd0, 2'd1, 1'b0, 32'h0000_4000, 32'h0000_0007, 16'hFFFE, 32'h0000_400C, 32'h0, 1'b0, 4'd5}, // R5
    '{2'd2, 2'd1, 2'd3, 1'b0, 32'h0000_0000, 32'h0000_0010, 16'h0000, 32'h0000_0080, 32'h0, 1'b0, 4'd5}, // R5 x8
    '{2'd3, 2'd3, 2'd2, 1'b0, 32'h0000_3000, 32'h0000_0055, 16'h0077, 32'h0000_3000, 32'h0000_3004, 1'b1, 4'd8}, // R8
    '{2'd3, 2'd2, 2'd3, 1'b1, 32'h0000_3000, 32'h0000_0011, 16'h0020, 32'h0000_2FF8, 32'h0000_2FF8, 1'b1, 4'd9}, // R9
    '{2'd3, 2'd0, 2'd0, 1'b1, 32'h0000_0000, 32'h0000_0000, 16'h0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 4'd11}, // R11
    '{2'd0, 2'd0, 2'd0, 1'b0, 32'hFFFF_FFF0, 32'h0000_0000, 16'h0020, 32'h0000_0010, 32'h0, 1'b0, 4'd11}, // R11
    '{2'd2, 2'd0, 2'd2, 1'b0, 32'h0000_0010, 32'hFFFF_FFFF, 16'h0000, 32'h0000_000C, 32'h0, 1'b0, 4'd11}, // R11
    '{2'd3, 2'd1, 2'd1, 1'b0, 32'hFFFF_FFFF, 32'h0000_0001, 16'h0003, 32'hFFFF_FFFF, 32'h0000_0001, 1'b1, 4'd8}  // R8 R10
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid = 1'b1; mode = v.m; scale = v.sc; opsize = v.sz; dir = v.d;
    base = v.b; index = v.x; disp = v.dp;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] held_ea;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk("R1 out_valid", {31'b0, out_valid}, 32'd0);
    chk("R1 wb_en", {31'b0, wb_en}, 32'd0);
    chk("R1 ea", ea, 32'd0);
    chk("R1 wb_data", wb_data, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      drive(VT[i]);
      @(negedge clk);
      chk($sformatf("vec %0d R%0d out_valid", i, VT[i].rq), {31'b0, out_valid}, 32'd1);
      chk($sformatf("vec %0d R%0d ea", i, VT[i].rq), ea, VT[i].e);
      chk($sformatf("vec %0d R%0d wb_data", i, VT[i].rq), wb_data, VT[i].w);
      chk($sformatf("vec %0d R10 wb_en", i), {31'b0, wb_en}, {31'b0, VT[i].we});
      in_valid = 1'b0;
      base = 32'hDEAD_BEEF;
      @(negedge clk);
      // R12 idle cycle holds results, R2 strobe lasts one cycle
      chk($sformatf("vec %0d R2 single pulse", i), {31'b0, out_valid}, 32'd0);
      chk($sformatf("vec %0d R12 ea held", i), ea, VT[i].e);
      chk($sformatf("vec %0d R12 wb_en low", i), {31'b0, wb_en}, 32'd0);
    end

    // R2 back-to-back requests
    drive(VT[2]);
    @(negedge clk);
    chk("R2 b2b first ea", ea, VT[2].e);
    drive(VT[9]);
    @(negedge clk);
    chk("R2 b2b second valid", {31'b0, out_valid}, 32'd1);
    chk("R2 b2b second ea", ea, VT[9].e);
    drive(VT[0]);
    @(negedge clk);
    chk("R10 wb_en drops after amod", {31'b0, wb_en}, 32'd0);
    chk("R10 wb_data zero", wb_data, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);

    // R12 long idle with changing inputs
    held_ea = ea;
    mode = 2'd2; index = 32'h1234; opsize = 2'd3;
    repeat (3) @(negedge clk);
    chk("R12 long idle ea", ea, held_ea);
    chk("R12 long idle valid", {31'b0, out_valid}, 32'd0);

    // R1 reset mid-run
    drive(VT[13]);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset ea", ea, 32'd0);
    chk("R1 async reset wb_en", {31'b0, wb_en}, 32'd0);
    chk("R1 async reset valid", {31'b0, out_valid}, 32'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule